// File: doc/BRIEF.md
# Multi-Target Clock and Reset Aligner

This block drives a group of target processors from one base clock so that their four-phase instruction cycles stay in lockstep. Every target divides its clock by four into phases Q1 to Q4 and sits in Q1 while held in reset. The block gives each target its own clock-enable gate on the shared clock and its own reset line. The reset release comes from a flop clocked by the base clock, so every target leaves reset on the same edge with full setup and hold margin. The reset is kept low for a minimum width. Around the release the shared clock is slowed, so that small differences in reset-path delay between targets cannot put them on different edges.

Once the targets run at full speed, each one sends a periodic sync pulse, typically from a timed interrupt routine. Target 0 is the reference. The block timestamps the rising edge of each pulse, compares every target with the reference inside a window that allows for output-pin skew, and reports lock per target. A target that is out of phase is pulled back by swallowing up to three of its clock-enable pulses. A target that stays silent past a programmable timeout is marked failed and held in reset until the next reset request.

The sequencer has six states. IDLE moves to HOLD_RESET on a request. HOLD_RESET moves to SLOW_RELEASE once the request is gone and the minimum width has elapsed. SLOW_RELEASE moves to FULL_SPEED after its slow pulses. FULL_SPEED moves to CHECK_LOCK after a settle period. CHECK_LOCK moves to REALIGN when a comparison calls for skipped pulses, and otherwise starts a new round. REALIGN returns to CHECK_LOCK after three cycles. A request in any state sends the sequencer to HOLD_RESET.

Top module: `mt_clk_aligner`

## Requirements
- R1: After `rst_n` is released the sequencer sits in IDLE (`seq_state` 0) until a request arrives. All `tgt_rst_n` are low, all `clk_en` are high, and `lock_ok`, `tgt_fail` and `ref_phase` are zero. State codes: IDLE 0, HOLD_RESET 1, SLOW_RELEASE 2, FULL_SPEED 3, CHECK_LOCK 4, REALIGN 5.
- R2: `reset_req` passes through a two-flop synchronizer. Once it is seen high, the sequencer enters HOLD_RESET from any state, drives every `tgt_rst_n` low, and clears `tgt_fail` and `lock_ok`.
- R3: HOLD_RESET lasts at least MIN_RST_CYC = MIN_RST_NS*CLK_MHZ/1000 cycles (40 by default) and continues for as long as the synchronized request stays high.
- R4: The release of `tgt_rst_n` comes from registered state, and all non-failed targets are released on the same clock edge.
- R5: In HOLD_RESET and SLOW_RELEASE, `clk_en` is high for one cycle in every SLOW_DIV (8), on the last cycle of each group counted from state entry. SLOW_RELEASE ends after SLOW_PULSES (4) such pulses. FULL_SPEED then holds all enables high for SETTLE_CYC (4) cycles before CHECK_LOCK.
- R6: `ref_phase` is 0 while targets are in reset. After the release it advances by one, modulo 4, on each cycle where `clk_en[0]` is high.
- R7: In CHECK_LOCK, with d = (cycle of the reference rising edge) minus (cycle of target i's rising edge), `lock_ok[i]` is set when |d| <= SKEW_TOL (3). `lock_ok[0]` is set when the reference pulse was seen.
- R8: A target that is seen but out of the window is given skip = d mod 4. REALIGN, three cycles long, holds that target's `clk_en` low in its first skip cycles. `clk_en[0]` is never skipped, and REALIGN is entered only if some skip is nonzero.
- R9: A target with no rising edge within `timeout_cyc` cycles of the start of a check round gets `tgt_fail` set, `tgt_rst_n` low and `lock_ok` low. This holds until the next request.
- R10: Failed targets are left out of later rounds, so a round finishes without waiting for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock shared by all targets |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| reset_req | input | 1 | Asynchronous request to reset the target array |
| sync_in | input | N_TGT | Sync pulse from each target, bit 0 is the reference |
| timeout_cyc | input | TW | Cycles allowed per check round before silent targets fail |
| clk_en | output | N_TGT | Per-target clock enable for the shared clock gate |
| tgt_rst_n | output | N_TGT | Per-target active-low reset |
| lock_ok | output | N_TGT | Target phase matched the reference in the last round |
| tgt_fail | output | N_TGT | Target timed out and is held in reset |
| ref_phase | output | 2 | Reference Q phase, 0 meaning Q1 |
| seq_state | output | 3 | Sequencer state code |

## Verification
The hardest situation to reach is a realign round in which several targets need different skip counts at the same time, including a negative offset that wraps to a skip of three and an offset of exactly four that fails lock without skipping. The bench gets there by timing the sync edge of every target against the reference from a table of offsets. It then counts the low enable cycles per target during the following REALIGN. A second hard case is a failed target being left out of later rounds. The bench reaches it by letting one target stay silent past a short timeout, then running a round whose completion would be impossible under the long timeout if that target were still awaited.

// File: rtl/mtca_pkg.sv
package mtca_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_HOLD    = 3'd1,
        ST_SLOW    = 3'd2,
        ST_FULL    = 3'd3,
        ST_CHECK   = 3'd4,
        ST_REALIGN = 3'd5
    } seq_state_t;
endpackage

// File: rtl/mtca_sync2.sv
// Two-stage synchronizer for asynchronous level inputs.
module mtca_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/mtca_stamp.sv
// Captures the free-running cycle count on the first rising edge of a
// target's sync pulse within a check round.
module mtca_stamp #(
    parameter int TSW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           arm,
    input  logic           flush,
    input  logic           pulse,
    input  logic [TSW-1:0] now,
    output logic           seen,
    output logic [TSW-1:0] stamp
);
    logic prev_q;
    logic rise;

    assign rise = pulse & ~prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            seen   <= 1'b0;
            stamp  <= '0;
        end else begin
            prev_q <= pulse;
            if (flush || !arm) begin
                seen <= 1'b0;
            end else if (rise && !seen) begin
                seen  <= 1'b1;
                stamp <= now;
            end
        end
    end
endmodule

// File: rtl/mtca_skip_gate.sv
// Per-target clock-enable gate that swallows a loaded number of pulses
// during the realign slots.
module mtca_skip_gate (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [1:0] skip_in,
    input  logic       active,
    input  logic [1:0] slot,
    input  logic       base_en,
    output logic       clk_en
);
    logic [1:0] skip_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    skip_q <= 2'd0;
        else if (load) skip_q <= skip_in;
    end

    assign clk_en = base_en & ~(active && (slot < skip_q));
endmodule

// File: rtl/mt_clk_aligner.sv
module mt_clk_aligner
    import mtca_pkg::*;
#(
    parameter int N_TGT       = 4,
    parameter int CLK_MHZ     = 20,
    parameter int MIN_RST_NS  = 2000,
    parameter int SLOW_DIV    = 8,
    parameter int SLOW_PULSES = 4,
    parameter int SETTLE_CYC  = 4,
    parameter int SKEW_TOL    = 3,
    parameter int TSW         = 8,
    parameter int TW          = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reset_req,
    input  logic [N_TGT-1:0] sync_in,
    input  logic [TW-1:0]    timeout_cyc,
    output logic [N_TGT-1:0] clk_en,
    output logic [N_TGT-1:0] tgt_rst_n,
    output logic [N_TGT-1:0] lock_ok,
    output logic [N_TGT-1:0] tgt_fail,
    output logic [1:0]       ref_phase,
    output logic [2:0]       seq_state
);
    localparam int MIN_RST_CYC = MIN_RST_NS * CLK_MHZ / 1000;
    localparam int CW = $clog2(MIN_RST_CYC + SETTLE_CYC + 2) + 1;
    localparam int DW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam int PW = (SLOW_PULSES > 1) ? $clog2(SLOW_PULSES) : 1;

    seq_state_t       state_q, state_n;
    logic             req_s;
    logic [N_TGT-1:0] sync_s;
    logic [CW-1:0]    cnt_q;
    logic [DW-1:0]    dcnt_q;
    logic [PW-1:0]    pcnt_q;
    logic [1:0]       slot_q;
    logic [TW-1:0]    to_q;
    logic [TSW-1:0]   now_q;
    logic [1:0]       ref_q;
    logic             rel_q, rel_n;
    logic [N_TGT-1:0] rst_q, lock_q, lock_n, fail_q, fail_n;
    logic [N_TGT-1:0] seen, lk_v;
    logic [TSW-1:0]   stamp [N_TGT];
    logic [1:0]       skip_v [N_TGT];
    logic             base_en, slow_tick, all_seen, timed_out, eval, any_skip;
    logic             in_check, in_realign;

    mtca_sync2 #(.W(1)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .d(reset_req), .q(req_s)
    );
    mtca_sync2 #(.W(N_TGT)) u_pulse_sync (
        .clk(clk), .rst_n(rst_n), .d(sync_in), .q(sync_s)
    );

    assign in_check   = (state_q == ST_CHECK);
    assign in_realign = (state_q == ST_REALIGN);
    assign slow_tick  = (dcnt_q == DW'(SLOW_DIV - 1));
    assign all_seen   = &(seen | fail_q);
    assign timed_out  = ({1'b0, to_q} + (TW+1)'(1)) >= {1'b0, timeout_cyc};
    assign eval       = in_check && (all_seen || timed_out);

    // Per-target timestamp, phase comparison and enable gate.
    for (genvar g = 0; g < N_TGT; g++) begin : g_tgt
        mtca_stamp #(.TSW(TSW)) u_stamp (
            .clk(clk), .rst_n(rst_n), .arm(in_check), .flush(eval),
            .pulse(sync_s[g]), .now(now_q), .seen(seen[g]), .stamp(stamp[g])
        );
        if (g == 0) begin : g_ref
            assign lk_v[0]   = seen[0] & ~fail_q[0];
            assign skip_v[0] = 2'd0;
        end else begin : g_cmp
            logic [TSW-1:0] dlt;
            logic           both, inwin;
            assign dlt   = stamp[0] - stamp[g];
            assign both  = seen[0] & seen[g] & ~fail_q[0] & ~fail_q[g];
            assign inwin = ($signed(dlt) <= SKEW_TOL) && ($signed(dlt) >= -SKEW_TOL);
            assign lk_v[g]   = both & inwin;
            assign skip_v[g] = (both && !inwin) ? dlt[1:0] : 2'd0;
        end
        mtca_skip_gate u_gate (
            .clk(clk), .rst_n(rst_n), .load(eval), .skip_in(skip_v[g]),
            .active(in_realign), .slot(slot_q), .base_en(base_en),
            .clk_en(clk_en[g])
        );
    end

    always_comb begin
        any_skip = 1'b0;
        for (int i = 0; i < N_TGT; i++) any_skip |= (skip_v[i] != 2'd0);
    end

    // Next-state and base enable.
    always_comb begin
        state_n = state_q;
        base_en = 1'b1;
        unique case (state_q)
            ST_IDLE: if (req_s) state_n = ST_HOLD;
            ST_HOLD: begin
                base_en = slow_tick;
                if (!req_s && cnt_q >= CW'(MIN_RST_CYC - 1)) state_n = ST_SLOW;
            end
            ST_SLOW: begin
                base_en = slow_tick;
                if (slow_tick && pcnt_q == PW'(SLOW_PULSES - 1)) state_n = ST_FULL;
            end
            ST_FULL:    if (cnt_q >= CW'(SETTLE_CYC - 1)) state_n = ST_CHECK;
            ST_CHECK:   if (eval && any_skip) state_n = ST_REALIGN;
            ST_REALIGN: if (slot_q == 2'd2) state_n = ST_CHECK;
            default:    state_n = ST_IDLE;
        endcase
        if (req_s) state_n = ST_HOLD;
    end

    // State register and sequencing counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            dcnt_q  <= '0;
            pcnt_q  <= '0;
            slot_q  <= 2'd0;
            to_q    <= '0;
            now_q   <= '0;
            ref_q   <= 2'd0;
        end else begin
            state_q <= state_n;
            if (state_n != state_q)   cnt_q <= '0;
            else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
            if (state_n != state_q || slow_tick) dcnt_q <= '0;
            else                                 dcnt_q <= dcnt_q + 1'b1;
            if (state_n != state_q)              pcnt_q <= '0;
            else if (state_q == ST_SLOW && slow_tick) pcnt_q <= pcnt_q + 1'b1;
            slot_q <= in_realign ? slot_q + 2'd1 : 2'd0;
            to_q   <= (!in_check || eval) ? '0 : to_q + 1'b1;
            now_q  <= now_q + 1'b1;
            if (!rel_q)         ref_q <= 2'd0;
            else if (clk_en[0]) ref_q <= ref_q + 2'd1;
        end
    end

    // Registered outputs.
    always_comb begin
        fail_n = fail_q;
        lock_n = lock_q;
        if (state_n == ST_HOLD) begin
            fail_n = '0;
            lock_n = '0;
        end else if (eval) begin
            fail_n = fail_q | ~seen;
            lock_n = lk_v;
        end
        rel_n = (state_n == ST_SLOW) || (state_n == ST_FULL) ||
                (state_n == ST_CHECK) || (state_n == ST_REALIGN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rel_q  <= 1'b0;
            rst_q  <= '0;
            fail_q <= '0;
            lock_q <= '0;
        end else begin
            rel_q  <= rel_n;
            rst_q  <= {N_TGT{rel_n}} & ~fail_n;
            fail_q <= fail_n;
            lock_q <= lock_n;
        end
    end

    assign tgt_rst_n = rst_q;
    assign lock_ok   = lock_q;
    assign tgt_fail  = fail_q;
    assign ref_phase = ref_q;
    assign seq_state = state_q;

    // Low-time counter used only by the width assertion.
    logic [CW-1:0] low_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           low_cnt <= '0;
        else if (rel_q)                       low_cnt <= '0;
        else if (low_cnt < CW'(MIN_RST_CYC))  low_cnt <= low_cnt + 1'b1;
    end

    a_r3_min_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rel_q) |-> (low_cnt >= CW'(MIN_RST_CYC)));

    a_r5_quiet_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rel_q) |-> (clk_en == '0));

    a_r6_phase_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!rel_q && $past(!rel_q)) |-> (ref_q == 2'd0));

    a_r8_ref_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL || state_q == ST_CHECK || state_q == ST_REALIGN)
        |-> clk_en[0]);

    a_r7_lock_not_failed: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q & fail_q) == '0);

    for (genvar a = 0; a < N_TGT; a++) begin : g_chk
        a_r9_fail_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
            fail_q[a] |-> !tgt_rst_n[a]);
    end
endmodule

// File: tb/mt_clk_aligner_tb.sv
`timescale 1ns/1ps
module mt_clk_aligner_tb;
    localparam int N    = 4;
    localparam int MINW = 40;
    localparam int SDIV = 8;
    localparam int TOL  = 3;
    localparam int BASE = 10;
    localparam int NV   = 5;
    // Offsets d of targets 1..3 relative to the reference (positive = early).
    localparam int DLT [NV][3] = '{
        '{ 0,  0,  0},
        '{ 3, -3,  1},
        '{ 5, -5,  4},
        '{ 6, -4,  7},
        '{-7,  2, -6}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reset_req;
    logic [N-1:0]  sync_in;
    logic [15:0]   timeout_cyc;
    logic [N-1:0]  clk_en, tgt_rst_n, lock_ok, tgt_fail;
    logic [1:0]    ref_phase;
    logic [2:0]    seq_state;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    mt_clk_aligner u_dut (
        .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .sync_in(sync_in),
        .timeout_cyc(timeout_cyc), .clk_en(clk_en), .tgt_rst_n(tgt_rst_n),
        .lock_ok(lock_ok), .tgt_fail(tgt_fail), .ref_phase(ref_phase),
        .seq_state(seq_state)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_state(input int s, input int maxc, input string tag);
        int n = 0;
        while (int'(seq_state) != s && n < maxc) begin
            @(negedge clk);
            n++;
        end
        chk(tag, int'(seq_state), s);
    endtask

    // One check round: drive sync edges at BASE - d, count low enables.
    task automatic run_round(input int d1, input int d2, input int d3,
                             input bit use3, input int ncyc,
                             output int sk [N]);
        for (int i = 0; i < N; i++) sk[i] = 0;
        for (int t = 0; t < ncyc; t++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) if (!clk_en[i]) sk[i]++;
            sync_in    = '0;
            sync_in[0] = (t == BASE);
            sync_in[1] = (t == BASE - d1);
            sync_in[2] = (t == BASE - d2);
            sync_in[3] = use3 && (t == BASE - d3);
        end
        sync_in = '0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n, ones, sk [N];
        bit ok;
        rst_n       = 1'b0;
        reset_req   = 1'b0;
        sync_in     = '0;
        timeout_cyc = 16'd1000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 state idle", int'(seq_state), 0);
        chk("R1 targets in reset", int'(tgt_rst_n), 0);
        chk("R1 enables high", int'(clk_en), 15);
        chk("R1 lock clear", int'(lock_ok), 0);
        chk("R1 fail clear", int'(tgt_fail), 0);
        chk("R1 phase zero", int'(ref_phase), 0);
        repeat (5) @(negedge clk);
        chk("R1 idle without request", int'(seq_state), 0);

        // R2/R3/R5 bring-up with a one-cycle request
        reset_req = 1'b1;
        @(negedge clk);
        reset_req = 1'b0;
        wait_state(1, 6, "R2 enter hold");
        n = 0; ones = 0; ok = 1;
        while (tgt_rst_n[0] == 1'b0 && n < 200) begin
            ones += int'(clk_en[0]);
            if (ref_phase != 2'd0) ok = 0;
            n++;
            @(negedge clk);
        end
        chk("R3 minimum hold width", n, MINW);
        chk("R5 slow pulses in hold", ones, MINW / SDIV);
        chk("R6 phase zero in reset", int'(ok), 1);
        chk("R4 all released together", int'(tgt_rst_n), 15);
        chk("R5 slow release state", int'(seq_state), 2);
        ok = 1;
        for (int k = 0; k < 32; k++) begin
            if (int'(clk_en) != ((k % SDIV == SDIV - 1) ? 15 : 0)) ok = 0;
            @(negedge clk);
        end
        chk("R5 slow enable pattern", int'(ok), 1);
        chk("R5 full speed state", int'(seq_state), 3);
        chk("R6 phase after slow window", int'(ref_phase), 0);
        chk("R5 full speed enables", int'(clk_en), 15);
        @(negedge clk);
        @(negedge clk);
        chk("R6 phase advances", int'(ref_phase), 2);
        @(negedge clk);
        @(negedge clk);
        chk("R5 check after settle", int'(seq_state), 4);

        // R7/R8 table-driven rounds
        for (int v = 0; v < NV; v++) begin
            int d, elk, esk;
            wait_state(4, 20, "R8 back to check");
            run_round(DLT[v][0], DLT[v][1], DLT[v][2], 1'b1, 32, sk);
            chk("R7 reference lock", int'(lock_ok[0]), 1);
            chk("R8 reference not skipped", sk[0], 0);
            for (int i = 1; i < N; i++) begin
                d   = DLT[v][i-1];
                elk = (d >= -TOL && d <= TOL) ? 1 : 0;
                esk = elk ? 0 : (d & 3);
                chk($sformatf("R7 lock v%0d t%0d", v, i), int'(lock_ok[i]), elk);
                chk($sformatf("R8 skip v%0d t%0d", v, i), sk[i], esk);
            end
        end

        // R9 timeout: target 3 stays silent
        wait_state(4, 20, "R9 in check");
        timeout_cyc = 16'd60;
        run_round(1, -1, 0, 1'b0, 80, sk);
        timeout_cyc = 16'd1000;
        chk("R9 fail flag", int'(tgt_fail), 8);
        chk("R9 failed held in reset", int'(tgt_rst_n), 7);
        chk("R9 lock without failed", int'(lock_ok), 7);

        // R10 failed target not awaited under long timeout
        wait_state(4, 20, "R10 in check");
        run_round(5, 0, 0, 1'b0, 32, sk);
        chk("R10 round finished lock", int'(lock_ok), 5);
        chk("R10 skip applied", sk[1], 1);
        chk("R10 still failed", int'(tgt_fail), 8);

        // R2/R3/R9 long request from a running state
        reset_req = 1'b1;
        wait_state(1, 6, "R2 hold from check");
        chk("R2 fail cleared", int'(tgt_fail), 0);
        chk("R2 lock cleared", int'(lock_ok), 0);
        chk("R2 all in reset", int'(tgt_rst_n), 0);
        n = 0;
        repeat (60) begin
            @(negedge clk);
            n++;
        end
        chk("R3 held while requested", int'(seq_state), 1);
        reset_req = 1'b0;
        while (tgt_rst_n[0] == 1'b0 && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk("R3 extended width", int'(n > MINW), 1);
        chk("R9 failed target released again", int'(tgt_rst_n), 15);
        wait_state(4, 80, "R5 reaches check again");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule